// File: doc/BRIEF.md
# Segment Offset Translator and Access Checker

This block turns a segment-relative offset into a linear address and decides in the same step whether the access is allowed. It keeps six hidden descriptor copies, one for each segment slot: code, data, stack, string destination and two general-purpose slots. Each copy holds a 32-bit base, a 20-bit limit and a small set of attribute bits. Software-side logic elsewhere fills these copies through a single write port. A translation therefore never reads a descriptor table in memory.

A request gives the role of the access, an optional override that moves a data access onto one of the extra slots, a write flag, the requester's privilege and a 32-bit offset. One cycle later the block returns the linear address (base plus offset, wrapping at 32 bits). It also returns a fault strobe and a 2-bit cause. Segments may grow upward or downward. Their limit may count bytes or 4 KB pages. Several segments may map the same linear range.

Top module: `seg_xlate_check`

## Requirements
- R1: A synchronous reset clears every slot to not-present and drops `rsp_valid`. An access made after reset and before any descriptor write faults with cause 00.
- R2: The role selects the slot. Role 00 (fetch) uses slot 0, role 01 (data) uses slot 1, role 10 (stack) uses slot 2 and role 11 (string destination) uses slot 3.
- R3: For role 01 only, `req_ovr` values 1, 2 and 3 route the access to slots 3, 4 and 5. The override has no effect for other roles.
- R4: `rsp_addr` equals the slot base plus the offset, modulo 2^32. It is reported one cycle after the request, including when the request faults.
- R5: In an expand-up slot (attr bit 3 = 0), offsets from 0 to the effective limit inclusive are legal. A larger offset faults with cause 01.
- R6: In an expand-down slot (attr bit 3 = 1), offsets from the effective limit up to 0xFFFFFFFF inclusive are legal. A smaller offset faults with cause 01.
- R7: With attr bit 4 set (page granularity), the effective limit is (limit << 12) | 0xFFF. With the bit clear, the effective limit is the 20-bit limit itself.
- R8: A request with `req_user` = 1 to a slot with attr bit 2 (supervisor-only) set faults with cause 10. A supervisor request is never refused for privilege.
- R9: A write request to a slot with attr bit 1 (read-only) set faults with cause 11. A fetch (role 00) is always treated as a read, whatever `req_write` says.
- R10: A slot with attr bit 0 (present) clear faults with cause 00 on every access.
- R11: When several faults apply, the reported cause is chosen in this order: not-present, then privilege, then limit, then write.
- R12: A descriptor write is used by requests from the following cycle onward. A request in the same cycle sees the old contents. A write to a slot number of 6 or above changes nothing.
- R13: `rsp_valid` pulses for exactly one cycle per request. `rsp_fault` is only high together with `rsp_valid`. `rsp_cause` is 00 whenever `rsp_fault` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_slot | input | 3 | Slot number to load |
| wr_base | input | 32 | Segment base |
| wr_limit | input | 20 | Segment limit |
| wr_attr | input | 5 | Attributes: [0] present, [1] read-only, [2] supervisor-only, [3] expand-down, [4] page granularity |
| req_valid | input | 1 | Request strobe |
| req_role | input | 2 | Access role: 00 fetch, 01 data, 10 stack, 11 string destination |
| req_ovr | input | 2 | Data override: 0 none, 1/2/3 for slots 3/4/5 |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Requester runs at user level |
| req_offset | input | 32 | Segment-relative offset |
| rsp_valid | output | 1 | Response strobe |
| rsp_addr | output | 32 | Linear address |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | 00 not present, 01 limit, 10 privilege, 11 write |

## Verification
The bench drives offsets at the effective limit itself and one or two either side of it, in both growth directions and both granularities. An off-by-one comparison, or a page limit missing its low 0xFFF fill, shows up there as a legal edge access that faults or an illegal one that passes. It also writes a descriptor in the same cycle as a request to that slot. A design that forwards the new write would then report the wrong base. Overrides on non-data roles, fetches carrying a write flag and stacked fault conditions check that the override is ignored outside the data role, that fetches never take a write fault, and that the cause priority is kept. A design that got any of these wrong would return the wrong slot's address or the wrong cause.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

  typedef struct packed {
    logic page;     // bit 4: limit counts 4 KB pages
    logic down;     // bit 3: expand-down
    logic superv;   // bit 2: supervisor-only
    logic ronly;    // bit 1: read-only
    logic present;  // bit 0: present
  } seg_attr_t;

  typedef enum logic [1:0] {
    ROLE_FETCH = 2'b00,
    ROLE_DATA  = 2'b01,
    ROLE_STACK = 2'b10,
    ROLE_STR   = 2'b11
  } seg_role_e;

  typedef enum logic [1:0] {
    CAUSE_ABSENT = 2'b00,
    CAUSE_LIMIT  = 2'b01,
    CAUSE_PRIV   = 2'b10,
    CAUSE_WRITE  = 2'b11
  } seg_cause_e;

  localparam int SLOT_CODE  = 0;
  localparam int SLOT_DATA  = 1;
  localparam int SLOT_STACK = 2;
  localparam int SLOT_STR   = 3;

endpackage

// File: rtl/segchk_shadow.sv
module segchk_shadow
  import segchk_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int ADDR_W    = 32,
  parameter int LIMIT_W   = 20,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  logic [ADDR_W-1:0]  wr_base,
  input  logic [LIMIT_W-1:0] wr_limit,
  input  seg_attr_t          wr_attr,
  input  logic [SLOT_W-1:0]  rd_slot,
  output logic [ADDR_W-1:0]  rd_base,
  output logic [LIMIT_W-1:0] rd_limit,
  output seg_attr_t          rd_attr
);

  logic [ADDR_W-1:0]  base_q  [NUM_SLOTS];
  logic [LIMIT_W-1:0] limit_q [NUM_SLOTS];
  seg_attr_t          attr_q  [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == SLOT_W'(s));
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[s]  <= '0;
        limit_q[s] <= '0;
        attr_q[s]  <= '0;
      end else if (hit) begin
        base_q[s]  <= wr_base;
        limit_q[s] <= wr_limit;
        attr_q[s]  <= wr_attr;
      end
    end
  end

  always_comb begin
    rd_base  = '0;
    rd_limit = '0;
    rd_attr  = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rd_slot == SLOT_W'(s)) begin
        rd_base  = base_q[s];
        rd_limit = limit_q[s];
        rd_attr  = attr_q[s];
      end
    end
  end

endmodule

// File: rtl/segchk_select.sv
module segchk_select
  import segchk_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [1:0]        role,
  input  logic [1:0]        ovr,
  output logic [SLOT_W-1:0] slot
);

  always_comb begin
    unique case (seg_role_e'(role))
      ROLE_FETCH: slot = SLOT_W'(SLOT_CODE);
      ROLE_STACK: slot = SLOT_W'(SLOT_STACK);
      ROLE_STR:   slot = SLOT_W'(SLOT_STR);
      default: begin
        if (ovr == 2'd0) slot = SLOT_W'(SLOT_DATA);
        else             slot = SLOT_W'(SLOT_STR) + SLOT_W'(ovr) - SLOT_W'(1);
      end
    endcase
  end

endmodule

// File: rtl/segchk_bounds.sv
module segchk_bounds #(
  parameter int ADDR_W     = 32,
  parameter int LIMIT_W    = 20,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [ADDR_W-1:0]  offset,
  input  logic [LIMIT_W-1:0] limit,
  input  logic               page,
  input  logic               down,
  output logic               in_range
);

  localparam int SCALED_W = LIMIT_W + PAGE_SHIFT;

  logic [ADDR_W-1:0]   eff_limit;
  logic [SCALED_W-1:0] scaled;

  assign scaled    = {limit, {PAGE_SHIFT{1'b1}}};
  assign eff_limit = page ? ADDR_W'(scaled) : ADDR_W'(limit);

  always_comb begin
    if (down) in_range = (offset >= eff_limit);
    else      in_range = (offset <= eff_limit);
  end

endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
  import segchk_pkg::*;
#(
  parameter int NUM_SLOTS  = 6,
  parameter int ADDR_W     = 32,
  parameter int LIMIT_W    = 20,
  parameter int PAGE_SHIFT = 12,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  logic [ADDR_W-1:0]  wr_base,
  input  logic [LIMIT_W-1:0] wr_limit,
  input  logic [4:0]         wr_attr,
  input  logic               req_valid,
  input  logic [1:0]         req_role,
  input  logic [1:0]         req_ovr,
  input  logic               req_write,
  input  logic               req_user,
  input  logic [ADDR_W-1:0]  req_offset,
  output logic               rsp_valid,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic               rsp_fault,
  output logic [1:0]         rsp_cause
);

  logic [SLOT_W-1:0]  sel_slot;
  logic [ADDR_W-1:0]  sel_base;
  logic [LIMIT_W-1:0] sel_limit;
  seg_attr_t          sel_attr;
  logic               in_range;
  logic               is_write;
  logic               f_absent, f_priv, f_limit, f_write;
  logic               any_fault;
  seg_cause_e         cause_d;

  segchk_select #(.NUM_SLOTS(NUM_SLOTS)) u_select (
    .role (req_role),
    .ovr  (req_ovr),
    .slot (sel_slot)
  );

  segchk_shadow #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .LIMIT_W   (LIMIT_W)
  ) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .wr_base  (wr_base),
    .wr_limit (wr_limit),
    .wr_attr  (seg_attr_t'(wr_attr)),
    .rd_slot  (sel_slot),
    .rd_base  (sel_base),
    .rd_limit (sel_limit),
    .rd_attr  (sel_attr)
  );

  segchk_bounds #(
    .ADDR_W     (ADDR_W),
    .LIMIT_W    (LIMIT_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_bounds (
    .offset   (req_offset),
    .limit    (sel_limit),
    .page     (sel_attr.page),
    .down     (sel_attr.down),
    .in_range (in_range)
  );

  assign is_write  = req_write && (seg_role_e'(req_role) != ROLE_FETCH);
  assign f_absent  = !sel_attr.present;
  assign f_priv    = req_user && sel_attr.superv;
  assign f_limit   = !in_range;
  assign f_write   = is_write && sel_attr.ronly;
  assign any_fault = f_absent || f_priv || f_limit || f_write;

  always_comb begin
    if (f_absent)     cause_d = CAUSE_ABSENT;
    else if (f_priv)  cause_d = CAUSE_PRIV;
    else if (f_limit) cause_d = CAUSE_LIMIT;
    else              cause_d = CAUSE_WRITE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= 2'b00;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && any_fault;
      rsp_cause <= (req_valid && any_fault) ? cause_d : 2'b00;
      if (req_valid) rsp_addr <= sel_base + req_offset;
    end
  end

endmodule

// File: rtl/seg_xlate_check_sva.sv
module seg_xlate_check_sva
  import segchk_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      req_valid,
  input logic [1:0] req_role,
  input logic      req_write,
  input logic      req_user,
  input logic      rsp_valid,
  input logic      rsp_fault,
  input logic [1:0] rsp_cause,
  input seg_attr_t sel_attr
);

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= !rst;

  AST_RSP_ONE_PER_REQ: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (rsp_valid == $past(req_valid))) else $error("AST_RSP_ONE_PER_REQ"); // R13

  AST_FAULT_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_valid) else $error("AST_FAULT_NEEDS_RSP"); // R13

  AST_CAUSE_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rsp_fault |-> (rsp_cause == 2'b00)) else $error("AST_CAUSE_IDLE_ZERO"); // R13

  AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(req_valid && !sel_attr.present)) |-> (rsp_fault && rsp_cause == CAUSE_ABSENT))
    else $error("AST_ABSENT_FAULTS"); // R10

  AST_USER_TO_SUPER: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(req_valid && req_user && sel_attr.present && sel_attr.superv))
      |-> (rsp_fault && rsp_cause == CAUSE_PRIV)) else $error("AST_USER_TO_SUPER"); // R8

  AST_FETCH_NO_WR_FAULT: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(req_valid && req_role == 2'b00 && req_write)) |-> (rsp_cause != CAUSE_WRITE))
    else $error("AST_FETCH_NO_WR_FAULT"); // R9

  AST_READ_NO_WR_FAULT: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(req_valid && !req_write)) |-> (rsp_cause != CAUSE_WRITE))
    else $error("AST_READ_NO_WR_FAULT"); // R9

endmodule

bind seg_xlate_check seg_xlate_check_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_role  (req_role),
  .req_write (req_write),
  .req_user  (req_user),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_cause (rsp_cause),
  .sel_attr  (sel_attr)
);

// File: tb/seg_xlate_check_bench.sv
module seg_xlate_check_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_slot = '0;
  logic [31:0] wr_base = '0;
  logic [19:0] wr_limit = '0;
  logic [4:0]  wr_attr = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_role = '0;
  logic [1:0]  req_ovr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [31:0] req_offset = '0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;

  always #2 clk = ~clk;

  seg_xlate_check u_seg_xlate_check (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .wr_base(wr_base),
    .wr_limit(wr_limit), .wr_attr(wr_attr), .req_valid(req_valid), .req_role(req_role),
    .req_ovr(req_ovr), .req_write(req_write), .req_user(req_user), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
  );

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // Reference model state
  logic [31:0] m_base [6];
  logic [19:0] m_lim  [6];
  logic [4:0]  m_attr [6];
  logic        exp_valid = 1'b0;
  logic        exp_fault = 1'b0;
  logic [1:0]  exp_cause = 2'b00;
  logic [31:0] exp_addr  = '0;

  function automatic int role_slot(input logic [1:0] role, input logic [1:0] ovr);
    if (role == 2'd0) return 0;
    if (role == 2'd2) return 2;
    if (role == 2'd3) return 3;
    if (ovr == 2'd0)  return 1;
    return 2 + int'(ovr);
  endfunction

  function automatic logic [31:0] eff_of(input int s);
    if (m_attr[s][4]) return {m_lim[s], 12'hFFF};
    return {12'h000, m_lim[s]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 6; i++) begin
        m_base[i] <= '0; m_lim[i] <= '0; m_attr[i] <= '0;
      end
      exp_valid <= 1'b0; exp_fault <= 1'b0; exp_cause <= 2'b00;
    end else begin
      exp_valid <= req_valid;
      if (req_valid) begin
        int s;
        logic [31:0] e;
        logic ok, wr;
        s  = role_slot(req_role, req_ovr);
        e  = eff_of(s);
        ok = m_attr[s][3] ? (req_offset >= e) : (req_offset <= e);
        wr = req_write && (req_role != 2'd0);
        exp_addr <= m_base[s] + req_offset;
        if (!m_attr[s][0])                    begin exp_fault <= 1'b1; exp_cause <= 2'b00; end
        else if (req_user && m_attr[s][2])    begin exp_fault <= 1'b1; exp_cause <= 2'b10; end
        else if (!ok)                         begin exp_fault <= 1'b1; exp_cause <= 2'b01; end
        else if (wr && m_attr[s][1])          begin exp_fault <= 1'b1; exp_cause <= 2'b11; end
        else                                  begin exp_fault <= 1'b0; exp_cause <= 2'b00; end
      end else begin
        exp_fault <= 1'b0; exp_cause <= 2'b00;
      end
      if (wr_en && wr_slot < 3'd6) begin
        m_base[wr_slot] <= wr_base;
        m_lim[wr_slot]  <= wr_limit;
        m_attr[wr_slot] <= wr_attr;
      end
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rsp_valid !== exp_valid || rsp_fault !== exp_fault || rsp_cause !== exp_cause ||
          (exp_valid && rsp_addr !== exp_addr)) begin
        fails++;
        $display("FAIL %s: valid/fault/cause/addr actual %b/%b/%b/%h expected %b/%b/%b/%h",
                 tag, rsp_valid, rsp_fault, rsp_cause, rsp_addr,
                 exp_valid, exp_fault, exp_cause, exp_addr);
      end
    end
  end

  task automatic load(input logic [2:0] s, input logic [31:0] b, input logic [19:0] l,
                      input logic [4:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = s; wr_base = b; wr_limit = l; wr_attr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic access(input logic [1:0] role, input logic [1:0] ovr, input logic wr,
                        input logic usr, input logic [31:0] off);
    @(negedge clk);
    req_valid = 1'b1; req_role = role; req_ovr = ovr; req_write = wr;
    req_user = usr; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: nothing loaded yet, every role faults as not present
    tag = "R1";
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: rsp_valid actual %b expected 0", rsp_valid);
    end
    for (int r = 0; r < 4; r++) access(2'(r), 2'd0, 1'b0, 1'b0, 32'h10);

    // R2 / R4: distinct bases per slot
    tag = "R2";
    for (int s = 0; s < 6; s++) load(3'(s), 32'h1000_0000 * (s + 1), 20'hFFFFF, 5'b10001);
    for (int r = 0; r < 4; r++) access(2'(r), 2'd0, 1'b0, 1'b0, 32'h0000_0123);
    tag = "R4";
    load(3'd1, 32'hFFFF_F000, 20'hFFFFF, 5'b10001);
    access(2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_2000);   // wraps
    // R3: override on data role, ignored on others
    tag = "R3";
    for (int o = 0; o < 4; o++) access(2'd1, 2'(o), 1'b0, 1'b0, 32'h44);
    for (int o = 1; o < 4; o++) begin
      access(2'd0, 2'(o), 1'b0, 1'b0, 32'h44);
      access(2'd2, 2'(o), 1'b0, 1'b0, 32'h44);
    end

    // R5: expand-up byte limit edges
    tag = "R5";
    load(3'd1, 32'h0000_8000, 20'h00FFF, 5'b00001);
    access(2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_0FFE);
    access(2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_0FFF);
    access(2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_1000);
    access(2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_0000);
    // R7: page granularity edges
    tag = "R7";
    load(3'd1, 32'h0000_8000, 20'h00003, 5'b10001);
    access(2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_3FFF);
    access(2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_4000);
    access(2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_0003);
    // R6: expand-down edges, byte then page
    tag = "R6";
    load(3'd2, 32'h2000_0000, 20'h00100, 5'b01001);
    access(2'd2, 2'd0, 1'b1, 1'b0, 32'h0000_00FF);
    access(2'd2, 2'd0, 1'b1, 1'b0, 32'h0000_0100);
    access(2'd2, 2'd0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    load(3'd2, 32'h2000_0000, 20'hFFFF0, 5'b11001);
    access(2'd2, 2'd0, 1'b0, 1'b0, 32'hFFFF_0FFE);
    access(2'd2, 2'd0, 1'b0, 1'b0, 32'hFFFF_0FFF);
    access(2'd2, 2'd0, 1'b0, 1'b0, 32'hFFFF_1000);

    // R8: privilege
    tag = "R8";
    load(3'd4, 32'h0300_0000, 20'hFFFFF, 5'b10101);
    access(2'd1, 2'd2, 1'b0, 1'b1, 32'h10);
    access(2'd1, 2'd2, 1'b0, 1'b0, 32'h10);
    // R9: read-only, fetch never write-faults
    tag = "R9";
    load(3'd0, 32'h0040_0000, 20'hFFFFF, 5'b10011);
    access(2'd0, 2'd0, 1'b1, 1'b0, 32'h20);
    load(3'd3, 32'h0050_0000, 20'hFFFFF, 5'b10011);
    access(2'd3, 2'd0, 1'b1, 1'b0, 32'h20);
    access(2'd3, 2'd0, 1'b0, 1'b0, 32'h20);
    // R10: present cleared
    tag = "R10";
    load(3'd5, 32'h0600_0000, 20'hFFFFF, 5'b10000);
    access(2'd1, 2'd3, 1'b0, 1'b0, 32'h0);
    // R11: stacked faults
    tag = "R11";
    load(3'd5, 32'h0600_0000, 20'h00010, 5'b00110);
    access(2'd1, 2'd3, 1'b1, 1'b1, 32'h1000);        // absent wins
    load(3'd5, 32'h0600_0000, 20'h00010, 5'b00111);
    access(2'd1, 2'd3, 1'b1, 1'b1, 32'h1000);        // privilege wins
    access(2'd1, 2'd3, 1'b1, 1'b0, 32'h1000);        // limit wins
    access(2'd1, 2'd3, 1'b1, 1'b0, 32'h0008);        // write only

    // R12: same-cycle write and request, out-of-range slot write
    tag = "R12";
    load(3'd1, 32'h0000_1000, 20'hFFFFF, 5'b10001);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = 3'd1; wr_base = 32'h0000_9000; wr_limit = 20'hFFFFF; wr_attr = 5'b10001;
    req_valid = 1'b1; req_role = 2'd1; req_ovr = 2'd0; req_write = 1'b0; req_user = 1'b0;
    req_offset = 32'h4;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    access(2'd1, 2'd0, 1'b0, 1'b0, 32'h4);
    load(3'd6, 32'hDEAD_0000, 20'h0, 5'b00000);
    load(3'd7, 32'hBEEF_0000, 20'h0, 5'b00000);
    for (int r = 0; r < 4; r++) access(2'(r), 2'd0, 1'b0, 1'b0, 32'h4);

    // R13 with mixed traffic near limits
    tag = "R13";
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      wr_en = ($urandom % 5) == 0;
      wr_slot = 3'($urandom % 7); wr_base = $urandom; wr_limit = 20'($urandom % 64);
      wr_attr = 5'($urandom);
      req_valid = ($urandom % 3) != 0;
      req_role = 2'($urandom); req_ovr = 2'($urandom);
      req_write = 1'($urandom); req_user = 1'($urandom);
      req_offset = eff_of(role_slot(req_role, req_ovr)) + 32'($urandom % 5) - 32'd2;
    end
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule